// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a small table of two-bit saturating counters. Each branch is mapped to one counter by a few bits of its program counter. The word-alignment bits are skipped, because they are always zero for 32-bit instructions. A fetch stage presents a PC on the lookup side and gets back a taken or not-taken guess in the same cycle, with no register in the path.

Later in the pipeline the branch resolves. The resolving stage then presents the branch's PC and its real direction on the training side, with a valid strobe. On the next clock edge the selected counter moves one step toward that direction. It never wraps past either end. A lookup made in the same cycle as a training write sees the counter's value from before the write. Reset clears every counter to the strongest not-taken state.

Top module: `bimodal_predictor`

## Requirements
- R1: Each counter stays within 0 to 3. A taken outcome at 3 leaves it at 3, and a not-taken outcome at 0 leaves it at 0.
- R2: A valid training request with `upd_taken`=1 raises the selected counter by one. A valid request with `upd_taken`=0 lowers it by one. Both are subject to R1.
- R3: `pred_taken` is 1 when the selected counter holds 2 or 3, and 0 when it holds 0 or 1.
- R4: The entry index is PC bits [ALIGN_BITS+IDX_W-1 : ALIGN_BITS], with IDX_W = log2(N_ENTRIES). With the defaults this is (pc >> 2) & 7. PC bits below and above that field have no effect on which entry is used.
- R5: A training request changes the counter on the rising clock edge. The lookup output reflects the change from the following cycle onward.
- R6: While `upd_valid` is 0, no counter changes, whatever `upd_pc` and `upd_taken` hold.
- R7: A synchronous active-high `rst` sets every counter to 0, so every lookup predicts not taken afterwards.
- R8: When a lookup and a valid training request select the same entry in the same cycle, the lookup returns the value from before the update.
- R9: A training request changes only the entry its PC selects. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all counters |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Combinational direction guess for `pred_pc` |
| upd_valid | input | 1 | Training request strobe |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real direction of the resolved branch |

## Verification
A run of repeated taken outcomes on one branch, followed by a longer run of not-taken outcomes, shows where the guess flips. This separates saturating counters from wrapping ones, and separates counters that train from counters that ignore their input. Training and lookup PCs that differ only outside the index field check the hashing. Strobe-low cycles carrying a taken outcome show that training is gated by the strobe. A same-entry lookup and training in the same cycle shows read-before-write ordering. A long pseudo-random stream of PCs and outcomes is compared every cycle against a behavioural table of integers. It catches errors in the index field and writes that land on the wrong entry.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_MIN = 2'd0;
  localparam ctr_t CTR_MAX = 2'd3;
endpackage

// File: rtl/bp_index_hash.sv
// Maps a PC to a counter index, skipping the alignment bits.
module bp_index_hash #(
  parameter int PC_W       = 32,
  parameter int ALIGN_BITS = 2,
  parameter int IDX_W      = 3
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  assign idx = pc[ALIGN_BITS +: IDX_W];
endmodule

// File: rtl/bp_sat_step.sv
// Computes the next value of one counter, saturating at both ends.
module bp_sat_step
  import bp_pkg::*;
(
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);
  always_comb begin
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : ctr_t'(cur + 2'd1);
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : ctr_t'(cur - 2'd1);
  end
endmodule

// File: rtl/bp_counter_table.sv
// Counter storage: two combinational read ports and one write port.
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ra_idx,
  output ctr_t             ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output ctr_t             rb_data,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  ctr_t             w_data
);
  logic [N_ENTRIES-1:0][1:0] ctr_q;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)                                 ctr_q[e] <= CTR_MIN;
      else if (we && w_idx == IDX_W'(e))       ctr_q[e] <= w_data;
    end
  end

  assign ra_data = ctr_q[ra_idx];
  assign rb_data = ctr_q[rb_idx];

  // R6: without a write strobe the whole table holds
  a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ctr_q));

  // R5: a write is visible at its entry after the edge
  a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> ctr_q[$past(w_idx)] == $past(w_data));

  // R9: entries other than the written one keep their value
  a_r9_neighbour_kept: assert property (@(posedge clk) disable iff (rst)
    (we && ra_idx != w_idx) |=> ctr_q[$past(ra_idx)] == $past(ra_data));
endmodule

// File: rtl/bimodal_predictor.sv
module bimodal_predictor
  import bp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int N_ENTRIES  = 8,
  parameter int ALIGN_BITS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int IDX_W = $clog2(N_ENTRIES);

  logic [IDX_W-1:0] pred_idx, upd_idx;
  ctr_t             pred_ctr, upd_ctr, upd_next;

  bp_index_hash #(.PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W)) u_hash_pred (
    .pc(pred_pc), .idx(pred_idx));
  bp_index_hash #(.PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W)) u_hash_upd (
    .pc(upd_pc), .idx(upd_idx));

  bp_counter_table #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .ra_idx(pred_idx), .ra_data(pred_ctr),
    .rb_idx(upd_idx),  .rb_data(upd_ctr),
    .we(upd_valid), .w_idx(upd_idx), .w_data(upd_next));

  bp_sat_step u_step (.cur(upd_ctr), .taken(upd_taken), .nxt(upd_next));

  assign pred_taken = pred_ctr[1];

  // R3: guess is taken exactly for counter values 2 and 3
  a_r3_decode: assert property (@(posedge clk) disable iff (rst)
    pred_taken == (pred_ctr >= 2'd2));
  // R1: saturation at the top
  a_r1_sat_high: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && upd_ctr == CTR_MAX) |-> upd_next == CTR_MAX);
  // R1: saturation at the bottom
  a_r1_sat_low: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && upd_ctr == CTR_MIN) |-> upd_next == CTR_MIN);
  // R2: taken steps up by one
  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && upd_ctr != CTR_MAX) |-> upd_next == upd_ctr + 2'd1);
  // R2: not taken steps down by one
  a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken && upd_ctr != CTR_MIN) |-> upd_next == upd_ctr - 2'd1);
  // R8: same-entry lookup during training shows the old value
  a_r8_read_before_write: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && pred_idx == upd_idx) |-> pred_ctr == upd_ctr);
endmodule

// File: tb/bimodal_predictor_bench.sv
module bimodal_predictor_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pred_pc = '0;
  logic        pred_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  int errors = 0;
  int checks = 0;
  int model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  bimodal_predictor u_bimodal_predictor (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  function automatic int ix(input logic [31:0] pc);
    return int'((pc >> 2) & 32'd7);
  endfunction

  task automatic check(input string tag, input logic [31:0] pc, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pc=%h: pred_taken=%0b expected %0b", tag, pc, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check, then let the model train after the rising edge.
  task automatic step(input logic [31:0] ppc, input logic v, input logic [31:0] upc,
                      input logic t, input string tag);
    @(negedge clk);
    pred_pc = ppc; upd_valid = v; upd_pc = upc; upd_taken = t;
    #1;
    check(tag, ppc, pred_taken, model[ix(ppc)] >= 2);
    @(posedge clk);
    if (v) begin
      if (t) model[ix(upc)] = (model[ix(upc)] == 3) ? 3 : model[ix(upc)] + 1;
      else   model[ix(upc)] = (model[ix(upc)] == 0) ? 0 : model[ix(upc)] - 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; upd_valid = 1'b0;
    repeat (2) @(posedge clk);
    foreach (model[i]) model[i] = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 8; i++) step(32'h0000_1000 + 32'(i * 4), 1'b0, '0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    sweep("R7");                                     // all entries start not taken

    // R2 / R1: five taken then not-taken on entry 3; guess flips after two steps
    for (int k = 0; k < 5; k++) step(32'h0000_000C, 1'b1, 32'h0000_000C, 1'b1, "R2");
    step(32'h0000_000C, 1'b0, '0, 1'b0, "R1");       // saturated at 3 -> taken
    for (int k = 0; k < 5; k++) step(32'h0000_000C, 1'b1, 32'h0000_000C, 1'b0, "R1");
    step(32'h0000_000C, 1'b0, '0, 1'b0, "R1");
    step(32'h0000_000C, 1'b1, 32'h0000_000C, 1'b1, "R2");
    step(32'h0000_000C, 1'b1, 32'h0000_000C, 1'b1, "R1");  // from 0 via 1 to 2
    step(32'h0000_000C, 1'b0, '0, 1'b0, "R1");       // expect taken (2)

    // R4: training with junk bits outside the index field aliases entry 1
    step(32'hFFF0_0004, 1'b1, 32'h0000_0007, 1'b1, "R4");
    step(32'hFFF0_0004, 1'b1, 32'hABC0_0025, 1'b1, "R4");
    step(32'h1230_0005, 1'b0, '0, 1'b0, "R4");
    step(32'h0000_0024, 1'b0, '0, 1'b0, "R4");       // entry 1 via bit 5 above field

    // R6: strobe low with taken outcome on entry 5 does nothing
    for (int k = 0; k < 4; k++) step(32'h0000_0014, 1'b0, 32'h0000_0014, 1'b1, "R6");

    // R8 / R5: entry 6 at 1, same-cycle lookup sees old, next cycle sees new
    step(32'h0000_0018, 1'b1, 32'h0000_0018, 1'b1, "R5");
    step(32'h0000_0018, 1'b1, 32'h0000_0018, 1'b1, "R8");
    step(32'h0000_0018, 1'b0, '0, 1'b0, "R5");

    // R9: all other entries unchanged
    sweep("R9");

    // R2: pattern nt,nt,nt,nt,t,nt,nt,nt,nt on entry 2 never predicts taken
    for (int k = 0; k < 9; k++)
      step(32'h0000_0008, 1'b1, 32'h0000_0008, (k == 4), "R2");

    // R4 / R9: pseudo-random stream against the model
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step({lfsr, lfsr[7:0], lfsr[15:8]}, lfsr[0] | lfsr[3],
           {lfsr[7:0], lfsr[15:8], lfsr}, lfsr[5] | lfsr[9], "R9");
    end

    // R7: reset clears trained entries
    for (int k = 0; k < 3; k++) step(32'h0000_001C, 1'b1, 32'h0000_001C, 1'b1, "R7");
    do_reset();
    sweep("R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule